// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter Engine

This block is a two-channel anti-aliasing low-pass filter. It runs up to eight second-order sections in series on 24-bit left and right samples. One multiplier-accumulator is shared by every tap, every section and both channels. A stereo sample pair enters on a one-cycle strobe. The engine filters the left sample through all active sections, then the right sample, and presents both results together on a one-cycle output strobe. The source must leave at least 12·(stage_sel+1)+1 cycles between filtered strobes. A strobe that arrives while the engine is busy is not taken.

Coefficients are held in a memory outside the block. The engine drives a word address and reads the word back combinationally in the same cycle. Section s occupies six consecutive words. A three-bit stage field selects how many sections run. An enable input chooses between filtering and a one-cycle pass-through. A clear input returns every section history to rest, and it is meant to be pulsed when a stream starts.

A sequencer with three states drives the operation:
- ST_IDLE waits for a strobe. It moves to ST_MAC when a strobe arrives with filtering enabled.
- ST_MAC runs five multiply-accumulate cycles, one per tap. It stays in ST_MAC while the tap is below 4 and moves to ST_FIN after tap 4.
- ST_FIN reads the shift word, saturates the section result and updates the histories. It moves back to ST_MAC while sections or the right channel remain, and to ST_IDLE after the last section of the right channel.
- The clear input forces ST_IDLE from any state.

Top module: `iir_biquad_cascade`

## Requirements
- R1: Coefficient words are 24-bit two's-complement fractions with 23 fraction bits. They are stored at address 6s+k, with k = 0..5 holding b0, b1, b2, a1, a2 and the shift. The shift is the low 3 bits of word 5.
- R1 (continued): Each section computes y = sat(floor((b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]) · 2^shift / 2^23)). The shift may differ from section to section, and a first-order section (b0 = 0, a2 = 0) is computed by the same rule.
- R2: When filt_en is 1, exactly stage_sel+1 sections run, in ascending order. Each section's output is the input of the next section, and the output of the last section is the channel result.
- R3: Only words of active sections affect the result. Words of sections at or above stage_sel+1 have no effect on the output.
- R4: Every section result is saturated to the range −8388608 … 8388607 before it is used further.
- R5: In filtered mode, out_valid is high for one cycle, exactly 12·(stage_sel+1) clock edges after the edge that samples in_valid. Each accepted strobe produces exactly one output.
- R6: When filt_en is 0 at the sampling edge, out_left and out_right equal the inputs on the next edge, with out_valid high. Such a sample leaves every section history unchanged.
- R7: The left and right channels keep independent histories. A right input of all zeros yields right outputs of zero whatever the left input is.
- R8: A pulse on clr_state zeroes all histories. The next filtered sample is computed as from rest.
- R9: After reset, out_valid, out_left and out_right are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| filt_en | input | 1 | 1: filter the sample, 0: pass it through |
| stage_sel | input | 3 | Number of active sections minus one |
| clr_state | input | 1 | Zero all section histories and abort a sample in progress |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| coef_addr | output | 6 | Coefficient word address, 6·section + word |
| coef_rdata | input | 24 | Coefficient word, read combinationally |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Left filtered sample |
| out_right | output | 24 | Right filtered sample |

## Verification
An impulse on the left channel with silence on the right shows the full recursive response. It separates the tap order, the sign of the feedback terms and the per-section shift, and it also shows whether the channels leak into each other. Two-tone sine inputs on 5-, 7- and 8-section sets, plus a single-section set, exercise the section count, the latency and the history update. Sections above the active count are filled with extreme values, so that reading one of them shows up at once. A large step drives every section into saturation. A set whose last section is first order covers the zero b0 and a2 case. Pass-through samples placed between filtered samples, and a clear after a filtered run, show that bypass leaves the histories untouched and that clear returns them to rest.

// File: rtl/iir_pkg.sv
`timescale 1ns/1ps
package iir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    localparam int WORDS_PER_SEC = 6;
    localparam int TAP_W         = 3;
    localparam logic [TAP_W-1:0] TAP_LAST_MAC = 3'd4;
    localparam logic [TAP_W-1:0] TAP_SHIFT    = 3'd5;
endpackage

// File: rtl/bq_seq.sv
`timescale 1ns/1ps
module bq_seq
    import iir_pkg::*;
#(
    parameter  int MAX_SEC = 8,
    localparam int SEC_W   = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1,
    localparam int ADDR_W  = $clog2(MAX_SEC * WORDS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              filt_en,
    input  logic [SEC_W-1:0]  stage_sel,
    output seq_state_t        state,
    output logic              ch,
    output logic [SEC_W-1:0]  sec,
    output logic [TAP_W-1:0]  tap,
    output logic              last_sec,
    output logic              start,
    output logic              pass,
    output logic              fin,
    output logic              emit,
    output logic [ADDR_W-1:0] coef_addr
);
    seq_state_t       nxt;
    logic [SEC_W-1:0] last_r;
    logic [SEC_W-1:0] last_sel;

    assign last_sel  = (int'(stage_sel) > MAX_SEC - 1) ? SEC_W'(MAX_SEC - 1) : stage_sel;
    assign start     = (state == ST_IDLE) && in_valid && filt_en;
    assign pass      = (state == ST_IDLE) && in_valid && !filt_en;
    assign fin       = (state == ST_FIN);
    assign last_sec  = (sec == last_r);
    assign emit      = fin && last_sec && ch;
    assign coef_addr = ADDR_W'(sec) * ADDR_W'(WORDS_PER_SEC) + ADDR_W'(tap);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (in_valid && filt_en) nxt = ST_MAC;
            ST_MAC:  if (tap == TAP_LAST_MAC) nxt = ST_FIN;
            ST_FIN:  nxt = (last_sec && ch) ? ST_IDLE : ST_MAC;
            default: nxt = ST_IDLE;
        endcase
    end

    // counters driven per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch     <= 1'b0;
            sec    <= '0;
            tap    <= '0;
            last_r <= '0;
        end else if (clr) begin
            ch  <= 1'b0;
            sec <= '0;
            tap <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ch     <= 1'b0;
                        sec    <= '0;
                        tap    <= '0;
                        last_r <= last_sel;
                    end
                end
                ST_MAC: begin
                    tap <= (tap == TAP_LAST_MAC) ? TAP_SHIFT : tap + 1'b1;
                end
                ST_FIN: begin
                    tap <= '0;
                    if (last_sec) begin
                        sec <= '0;
                        ch  <= 1'b1;
                    end else begin
                        sec <= sec + 1'b1;
                    end
                end
                default: tap <= '0;
            endcase
        end
    end

    // R3: no address beyond the active sections while busy
    p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (int'(coef_addr) <= int'(last_r) * WORDS_PER_SEC + WORDS_PER_SEC - 1));

    // R1: a section result is formed only after all five taps
    p_fin_after_mac_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |-> ($past(state) == ST_MAC && $past(tap) == TAP_LAST_MAC));
endmodule

// File: rtl/bq_hist.sv
`timescale 1ns/1ps
module bq_hist #(
    parameter  int DW      = 24,
    parameter  int MAX_SEC = 8,
    localparam int SEC_W   = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1,
    localparam int IDX_W   = $clog2(MAX_SEC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ch,
    input  logic [SEC_W-1:0]     sec,
    input  logic                 wr,
    input  logic                 wr_last,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] y_in,
    output logic signed [DW-1:0] xd1,
    output logic signed [DW-1:0] xd2,
    output logic signed [DW-1:0] yd1,
    output logic signed [DW-1:0] yd2
);
    // Node j holds the two delayed values of the signal entering section j;
    // node j+1 is then both the output history of j and the input history of j+1.
    logic [IDX_W-1:0] ix, iy;
    logic signed [DW-1:0] rx1 [2];
    logic signed [DW-1:0] rx2 [2];
    logic signed [DW-1:0] ry1 [2];
    logic signed [DW-1:0] ry2 [2];

    assign ix = IDX_W'(sec);
    assign iy = ix + 1'b1;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic signed [DW-1:0] d1 [MAX_SEC+1];
        logic signed [DW-1:0] d2 [MAX_SEC+1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int j = 0; j <= MAX_SEC; j++) begin
                    d1[j] <= '0;
                    d2[j] <= '0;
                end
            end else if (clr) begin
                for (int j = 0; j <= MAX_SEC; j++) begin
                    d1[j] <= '0;
                    d2[j] <= '0;
                end
            end else if (wr && (ch == 1'(c))) begin
                d1[ix] <= x_in;
                d2[ix] <= d1[ix];
                if (wr_last) begin
                    d1[iy] <= y_in;
                    d2[iy] <= d1[iy];
                end
            end
        end

        assign rx1[c] = d1[ix];
        assign rx2[c] = d2[ix];
        assign ry1[c] = d1[iy];
        assign ry2[c] = d2[iy];
    end

    assign xd1 = rx1[ch];
    assign xd2 = rx2[ch];
    assign yd1 = ry1[ch];
    assign yd2 = ry2[ch];

    // R8: a clear leaves every history at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (xd1 == 0 && xd2 == 0 && yd1 == 0 && yd2 == 0));
endmodule

// File: rtl/bq_mac.sv
`timescale 1ns/1ps
module bq_mac
    import iir_pkg::*;
#(
    parameter  int DW    = 24,
    localparam int ACC_W = 2 * DW + 3,
    localparam int FRAC  = DW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [TAP_W-1:0]     tap,
    input  logic [DW-1:0]        coef,
    input  logic signed [DW-1:0] x_cur,
    input  logic signed [DW-1:0] xd1,
    input  logic signed [DW-1:0] xd2,
    input  logic signed [DW-1:0] yd1,
    input  logic signed [DW-1:0] yd2,
    output logic signed [DW-1:0] y
);
    localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0]    op;
    logic signed [ACC_W-1:0] c_ext, o_ext, prod, term, acc, scaled;
    logic                    feedback;
    int                      shamt;

    always_comb begin
        case (tap)
            3'd0:    op = x_cur;
            3'd1:    op = xd1;
            3'd2:    op = xd2;
            3'd3:    op = yd1;
            3'd4:    op = yd2;
            default: op = '0;
        endcase
    end

    assign feedback = (tap == 3'd3) || (tap == 3'd4);
    assign c_ext    = {{(ACC_W-DW){coef[DW-1]}}, coef};
    assign o_ext    = {{(ACC_W-DW){op[DW-1]}}, op};
    assign prod     = c_ext * o_ext;
    assign term     = feedback ? -prod : prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc <= '0;
        else if (step) acc <= ((tap == 3'd0) ? '0 : acc) + term;
    end

    // output scaling by the section shift word, then saturation
    always_comb begin
        shamt  = FRAC - ((int'(coef[2:0]) > FRAC) ? FRAC : int'(coef[2:0]));
        scaled = acc >>> shamt;
        if (scaled > SAT_HI)      y = SAT_HI[DW-1:0];
        else if (scaled < SAT_LO) y = SAT_LO[DW-1:0];
        else                      y = scaled[DW-1:0];
    end
endmodule

// File: rtl/iir_biquad_cascade.sv
`timescale 1ns/1ps
module iir_biquad_cascade
    import iir_pkg::*;
#(
    parameter  int DATA_W  = 24,
    parameter  int MAX_SEC = 8,
    localparam int SEC_W   = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1,
    localparam int ADDR_W  = $clog2(MAX_SEC * WORDS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic [SEC_W-1:0]  stage_sel,
    input  logic              clr_state,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic [ADDR_W-1:0] coef_addr,
    input  logic [DATA_W-1:0] coef_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    seq_state_t           state;
    logic                 ch, last_sec, start, pass, fin, emit;
    logic [SEC_W-1:0]     sec;
    logic [TAP_W-1:0]     tap;
    logic signed [DATA_W-1:0] x_cur, x_right_r, res_left, y;
    logic signed [DATA_W-1:0] xd1, xd2, yd1, yd2;

    bq_seq #(.MAX_SEC(MAX_SEC)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr_state), .in_valid(in_valid),
        .filt_en(filt_en), .stage_sel(stage_sel), .state(state), .ch(ch),
        .sec(sec), .tap(tap), .last_sec(last_sec), .start(start), .pass(pass),
        .fin(fin), .emit(emit), .coef_addr(coef_addr)
    );

    bq_hist #(.DW(DATA_W), .MAX_SEC(MAX_SEC)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(clr_state), .ch(ch), .sec(sec),
        .wr(fin), .wr_last(fin && last_sec), .x_in(x_cur), .y_in(y),
        .xd1(xd1), .xd2(xd2), .yd1(yd1), .yd2(yd2)
    );

    bq_mac #(.DW(DATA_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .step(state == ST_MAC), .tap(tap),
        .coef(coef_rdata), .x_cur(x_cur), .xd1(xd1), .xd2(xd2),
        .yd1(yd1), .yd2(yd2), .y(y)
    );

    // section input and channel result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_cur     <= '0;
            x_right_r <= '0;
            res_left  <= '0;
        end else if (start) begin
            x_cur     <= in_left;
            x_right_r <= in_right;
        end else if (fin) begin
            if (last_sec && !ch) begin
                x_cur    <= x_right_r;
                res_left <= y;
            end else begin
                x_cur <= y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= pass || emit;
            if (pass) begin
                out_left  <= in_left;
                out_right <= in_right;
            end else if (emit) begin
                out_left  <= res_left;
                out_right <= y;
            end
        end
    end

    // R6: bypassed samples appear unchanged one edge later
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (out_valid && out_left == $past(in_left) && out_right == $past(in_right)));
endmodule

// File: tb/tb_iir_biquad_cascade.sv
`timescale 1ns/1ps
module tb_iir_biquad_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filt_en = 1'b0;
    logic [2:0]  stage_sel = 3'd0;
    logic        clr_state = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [5:0]  coef_addr;
    logic [23:0] coef_rdata;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    logic [23:0] coef_mem [48];
    assign coef_rdata = (coef_addr < 6'd48) ? coef_mem[coef_addr] : 24'h0;

    iir_biquad_cascade dut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .stage_sel(stage_sel),
        .clr_state(clr_state), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .coef_addr(coef_addr), .coef_rdata(coef_rdata),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    int q_l[$], q_r[$], q_due[$];
    string q_tag[$];
    int m_x1[2][8], m_x2[2][8], m_y1[2][8], m_y2[2][8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat24(longint v);
        if (v > 64'sd8388607)  return 8388607;
        if (v < -64'sd8388608) return -8388608;
        return int'(v);
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 8; s++) begin
                m_x1[c][s] = 0; m_x2[c][s] = 0; m_y1[c][s] = 0; m_y2[c][s] = 0;
            end
    endtask

    task automatic model(input int l, input int r, output int ol, output int orr);
        int res[2];
        int xin[2];
        xin[0] = l; xin[1] = r;
        for (int c = 0; c < 2; c++) begin
            int x;
            x = xin[c];
            for (int s = 0; s <= int'(stage_sel); s++) begin
                int cf[5];
                int sh, yv;
                longint acc;
                for (int k = 0; k < 5; k++) cf[k] = $signed(coef_mem[6*s+k]);
                sh = int'(coef_mem[6*s+5][2:0]);
                acc = longint'(cf[0]) * x + longint'(cf[1]) * m_x1[c][s]
                    + longint'(cf[2]) * m_x2[c][s] - longint'(cf[3]) * m_y1[c][s]
                    - longint'(cf[4]) * m_y2[c][s];
                yv = sat24(acc >>> (23 - sh));
                m_x2[c][s] = m_x1[c][s]; m_x1[c][s] = x;
                m_y2[c][s] = m_y1[c][s]; m_y1[c][s] = yv;
                x = yv;
            end
            res[c] = x;
        end
        ol = res[0]; orr = res[1];
    endtask

    // nact active sections, poisoned words above them; optional first-order last section
    task automatic load_set(int nact, bit first_order_last);
        for (int s = 0; s < 8; s++) begin
            int sh;
            sh = 1 + (s % 4);
            if (s >= nact) begin
                for (int k = 0; k < 5; k++) coef_mem[6*s+k] = 24'h7fffff;
                coef_mem[6*s+5] = 24'd7;
            end else if (first_order_last && s == nact - 1) begin
                coef_mem[6*s+0] = 24'd0;
                coef_mem[6*s+1] = 24'(2097152 >> sh);
                coef_mem[6*s+2] = 24'(2097152 >> sh);
                coef_mem[6*s+3] = 24'(-(4194304 >> sh));
                coef_mem[6*s+4] = 24'd0;
                coef_mem[6*s+5] = 24'(sh);
            end else begin
                coef_mem[6*s+0] = 24'(1048576 >> sh);
                coef_mem[6*s+1] = 24'(2097152 >> sh);
                coef_mem[6*s+2] = 24'(1048576 >> sh);
                coef_mem[6*s+3] = 24'(-(8388608 >> sh));
                coef_mem[6*s+4] = 24'(2097152 >> sh);
                coef_mem[6*s+5] = 24'(sh);
            end
        end
    endtask

    task automatic send(int l, int r, string tag);
        int el, er, lat;
        @(negedge clk);
        if (filt_en) begin
            model(l, r, el, er);
            lat = 12 * (int'(stage_sel) + 1);
        end else begin
            el = l; er = r; lat = 0;
        end
        q_l.push_back(el); q_r.push_back(er); q_due.push_back(cyc + 1 + lat); q_tag.push_back(tag);
        in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (lat + 1) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_state = 1'b1;
        model_clear();
        @(negedge clk);
        clr_state = 1'b0;
    endtask

    task automatic sines(int n, string tag);
        for (int k = 0; k < n; k++)
            send($rtoi(3000.0 * $sin(6.2831853 * k / 16.0)),
                 $rtoi(2000.0 * $sin(6.2831853 * k / 5.0)), tag);
    endtask

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q_due.size() > 0 && q_due[0] < cyc) begin
                chk(0, "R5", "missing output", cyc, q_due[0]);
                void'(q_l.pop_front()); void'(q_r.pop_front());
                void'(q_due.pop_front()); void'(q_tag.pop_front());
            end
            if (out_valid) begin
                if (q_due.size() == 0) begin
                    chk(0, "R5", "unexpected out_valid", 1, 0);
                end else begin
                    chk(q_due[0] == cyc, "R5", "output cycle", cyc, q_due[0]);
                    chk($signed(out_left) == q_l[0], q_tag[0], "left", $signed(out_left), q_l[0]);
                    chk($signed(out_right) == q_r[0], q_tag[0], "right", $signed(out_right), q_r[0]);
                    void'(q_l.pop_front()); void'(q_r.pop_front());
                    void'(q_due.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    initial begin
        #(5.0 * 190000);
        chk(0, "watchdog", "timeout", cyc, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        load_set(8, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
        chk(out_left == 24'd0, "R9", "out_left", int'(out_left), 0);
        chk(out_right == 24'd0, "R9", "out_right", int'(out_right), 0);

        // R6 bypass, extremes included
        filt_en = 1'b0;
        send(8388607, -8388608, "R6");
        send(-1, 12345, "R6");
        send(0, 777, "R6");

        // 5 sections, left impulse, silent right: R1, R2, R3, R7
        filt_en = 1'b1; stage_sel = 3'd4;
        load_set(5, 0);
        pulse_clear();
        send(100000, 0, "R1,R7");
        for (int k = 0; k < 15; k++) send(0, 0, "R1,R3,R7");

        // R6 bypass between filtered samples keeps histories
        filt_en = 1'b0;
        send(5000, -5000, "R6");
        send(-7000, 9000, "R6");
        filt_en = 1'b1;
        for (int k = 0; k < 6; k++) send(0, 0, "R6");

        // R8 clear after a run, then impulse on the right
        send(40000, 20000, "R8");
        pulse_clear();
        send(0, 60000, "R8");
        for (int k = 0; k < 8; k++) send(0, 0, "R8");

        // 7 and 8 sections with sines: R2
        stage_sel = 3'd6; load_set(7, 0); pulse_clear();
        sines(32, "R2,R3");
        stage_sel = 3'd7; load_set(8, 0); pulse_clear();
        sines(32, "R2");

        // single section boundary: R2
        stage_sel = 3'd0; load_set(1, 0); pulse_clear();
        send(1000000, -1000000, "R2");
        for (int k = 0; k < 7; k++) send(0, 0, "R2");

        // R4 saturation with a large step
        stage_sel = 3'd4; load_set(5, 0); pulse_clear();
        for (int k = 0; k < 8; k++) send(6291456, -6291456, "R4");

        // first-order last section: R1
        load_set(5, 1); pulse_clear();
        send(200000, -50000, "R1");
        for (int k = 0; k < 10; k++) send(0, 0, "R1");
        sines(16, "R1");

        repeat (10) @(negedge clk);
        chk(q_due.size() == 0, "R5", "outputs left pending", q_due.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule